// File: doc/BRIEF.md
# Two's-Complement Floating-Point Adder

This block adds two numbers that share one parameterised format. Each number has a signed exponent of `EXP_W` bits and a two's-complement significand of `MAN_W` bits. A number's value is the significand, read as an integer, times two to the power of the exponent. A non-zero significand is normalised when its two top bits differ. An all-zero significand means zero, whatever the exponent field holds.

Each operand comes with its own valid strobe. An addition starts in a cycle where both strobes are high. The first stage compares the exponents and swaps the operands so that the smaller one goes through a saturating arithmetic right shifter, which keeps one guard bit. The second stage adds the two significands, one bit wider than the operands so that overflow is kept. It then counts the redundant sign bits of the sum and shifts them out, and finally rounds or truncates on the guard bit. The result leaves a register with its own valid flag.

Top module: `tc_float_adder`

## Requirements
- R1: A result valid pulse appears on the second rising clock edge after an edge at which both operand strobes were high. A cycle in which only one strobe is high produces no result.
- R2: The smaller operand's significand, with one zero guard bit appended below it, is arithmetically shifted right by the exponent difference. Bits below the guard bit are dropped, which floors the value. It is then added to the larger operand's significand, which also carries a zero guard bit.
- R3: Operand order does not matter. When the exponents are equal, the first operand is taken as the larger.
- R4: When the exponent difference is `MAN_W+1` or more, the aligned smaller word is pure sign. A far positive operand leaves the larger one unchanged. A far negative one subtracts one unit at the guard position.
- R5: When two same-sign values overflow the significand, the result is shifted right by one with its sign kept, and the exponent becomes the larger exponent plus one.
- R6: Every non-zero result is normalised (bit `MAN_W-1` differs from bit `MAN_W-2`). The exponent is lowered by one for each redundant sign bit removed.
- R7: A zero sum gives a zero significand with the minimum exponent (bit `EXP_W-1` set, all other bits clear).
- R8: An operand with a zero significand counts as having the minimum exponent. The other operand is therefore returned unchanged.
- R9: With `RND_MODE` set to half-up, the guard bit is added to the kept significand. A carry out of the significand is renormalised by a one-bit right shift and an exponent increment. A result that loses normalisation is shifted left by one with an exponent decrement. With truncation, the guard bit is dropped.
- R10: A new addition can start on every clock cycle, and results come out in the order the additions started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | First operand strobe |
| a_exp_i | input | EXP_W | First operand exponent, two's complement |
| a_sig_i | input | MAN_W | First operand significand, two's complement |
| b_valid_i | input | 1 | Second operand strobe |
| b_exp_i | input | EXP_W | Second operand exponent, two's complement |
| b_sig_i | input | MAN_W | Second operand significand, two's complement |
| sum_valid_o | output | 1 | Result valid |
| sum_exp_o | output | EXP_W | Result exponent |
| sum_sig_o | output | MAN_W | Result significand, normalised or zero |

## Verification
Every sum is due exactly two rising edges after the edge that captured both strobes. One register holds the aligned operands, and the other holds the result. The bench changes inputs on falling edges and reads the outputs on the falling edge that follows the second rising edge. At that point it checks the valid flag, the exponent and the significand together. For the strobe test, the bench watches several cycles after a single-strobe input. For the streaming test, it starts three additions on consecutive cycles and expects their results on three consecutive falling edges, in the same order.

// File: rtl/tcfa_pkg.sv
package tcfa_pkg;
  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_HALF_UP = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/tcfa_align.sv
module tcfa_align #(
  parameter int EXP_W = 6,
  parameter int MAN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [MAN_W-1:0] a_sig_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [MAN_W-1:0] b_sig_i,
  output logic [EXP_W-1:0] big_exp_o,
  output logic [MAN_W:0]   big_ext_o,
  output logic [MAN_W:0]   small_al_o
);
  localparam int W1   = MAN_W + 1;
  localparam int DW   = EXP_W + 1;
  localparam int SH_W = $clog2(W1 + 1);
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic [EXP_W-1:0] a_eff, b_eff, small_exp;
  logic [DW-1:0]    diff, diff_abs;
  logic             swap;
  logic [MAN_W-1:0] big_sig, small_sig;
  logic [SH_W-1:0]  shamt;

  // zero operands never win the exponent compare
  assign a_eff = (a_sig_i == '0) ? EXP_MIN : a_exp_i;
  assign b_eff = (b_sig_i == '0) ? EXP_MIN : b_exp_i;

  assign diff     = {a_eff[EXP_W-1], a_eff} - {b_eff[EXP_W-1], b_eff};
  assign swap     = diff[DW-1];
  assign diff_abs = swap ? (~diff + 1'b1) : diff;

  // exchange network
  assign big_exp_o = swap ? b_eff   : a_eff;
  assign small_exp = swap ? a_eff   : b_eff;
  assign big_sig   = swap ? b_sig_i : a_sig_i;
  assign small_sig = swap ? a_sig_i : b_sig_i;

  assign shamt = (diff_abs >= DW'(W1)) ? SH_W'(W1) : SH_W'(diff_abs);

  assign big_ext_o  = {big_sig, 1'b0};
  assign small_al_o = $signed({small_sig, 1'b0}) >>> shamt;

  a_r3_big_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($signed(big_exp_o) >= $signed(small_exp)));

  a_r4_far_is_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && shamt == SH_W'(W1)) |-> (small_al_o == {W1{small_sig[MAN_W-1]}}));
endmodule

// File: rtl/tcfa_rsb_count.sv
module tcfa_rsb_count #(
  parameter int W     = 8,
  parameter int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     word_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-2:0] run;

  assign run[W-2] = word_i[W-2] ~^ word_i[W-1];
  for (genvar i = W - 3; i >= 0; i--) begin : g_run
    assign run[i] = run[i+1] & (word_i[i] ~^ word_i[W-1]);
  end

  assign cnt_o = CNT_W'($countones(run));
endmodule

// File: rtl/tcfa_norm_round.sv
module tcfa_norm_round
  import tcfa_pkg::*;
#(
  parameter int        EXP_W    = 6,
  parameter int        MAN_W    = 6,
  parameter rnd_mode_e RND_MODE = RND_HALF_UP,
  parameter int        W2       = MAN_W + 2,
  parameter int        CNT_W    = $clog2(W2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W2-1:0]    sum_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [EXP_W-1:0] big_exp_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] sig_o
);
  localparam int XW = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic [W2-1:0]    norm;
  logic [MAN_W-1:0] pre_sig, fin_sig;
  logic             guard, unused_lsb, is_zero;
  logic [XW-1:0]    e0, fin_exp;
  logic [XW-EXP_W-1:0] unused_hi;

  assign norm       = sum_i << cnt_i;
  assign pre_sig    = norm[W2-1:2];
  assign guard      = norm[1];
  assign unused_lsb = norm[0];
  assign is_zero    = (sum_i == '0);

  // sum lsb sits one below big lsb, kept field sits two above: +1 - shift
  assign e0 = XW'($signed(big_exp_i)) + XW'(1) - XW'(cnt_i);

  if (RND_MODE == RND_HALF_UP) begin : g_round
    logic [MAN_W:0] r_ext;
    logic           ovf, shl;
    assign r_ext = {pre_sig[MAN_W-1], pre_sig} + {{MAN_W{1'b0}}, guard};
    assign ovf   = r_ext[MAN_W] ^ r_ext[MAN_W-1];
    assign shl   = !ovf && (r_ext[MAN_W-1] == r_ext[MAN_W-2]) && (r_ext != '0);
    assign fin_sig = ovf ? r_ext[MAN_W:1]
                   : shl ? {r_ext[MAN_W-2:0], 1'b0}
                   : r_ext[MAN_W-1:0];
    assign fin_exp = e0 + (ovf ? XW'(1) : XW'(0)) - (shl ? XW'(1) : XW'(0));
  end else begin : g_trunc
    logic unused_guard;
    assign unused_guard = guard;
    assign fin_sig = pre_sig;
    assign fin_exp = e0;
  end

  assign unused_hi = fin_exp[XW-1:EXP_W];
  assign sig_o = is_zero ? '0      : fin_sig;
  assign exp_o = is_zero ? EXP_MIN : fin_exp[EXP_W-1:0];

  a_r6_shift_normalises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_zero) |-> (norm[W2-1] != norm[W2-2]));

  a_r7_zero_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_zero) |-> (sig_o == '0 && exp_o == EXP_MIN));
endmodule

// File: rtl/tc_float_adder.sv
module tc_float_adder
  import tcfa_pkg::*;
#(
  parameter int        EXP_W    = 6,
  parameter int        MAN_W    = 6,
  parameter rnd_mode_e RND_MODE = RND_HALF_UP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_valid_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic [MAN_W-1:0] a_sig_i,
  input  logic             b_valid_i,
  input  logic [EXP_W-1:0] b_exp_i,
  input  logic [MAN_W-1:0] b_sig_i,
  output logic             sum_valid_o,
  output logic [EXP_W-1:0] sum_exp_o,
  output logic [MAN_W-1:0] sum_sig_o
);
  localparam int W1    = MAN_W + 1;
  localparam int W2    = MAN_W + 2;
  localparam int CNT_W = $clog2(W2);
  localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic             go;
  logic [EXP_W-1:0] al_big_exp;
  logic [W1-1:0]    al_big_ext, al_small;

  logic             s1_valid;
  logic [EXP_W-1:0] s1_big_exp;
  logic [W1-1:0]    s1_big_ext, s1_small;

  logic [W2-1:0]    sum;
  logic [CNT_W-1:0] rsb;
  logic [EXP_W-1:0] nr_exp;
  logic [MAN_W-1:0] nr_sig;

  assign go = a_valid_i & b_valid_i;

  tcfa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (go),
    .a_exp_i   (a_exp_i),
    .a_sig_i   (a_sig_i),
    .b_exp_i   (b_exp_i),
    .b_sig_i   (b_sig_i),
    .big_exp_o (al_big_exp),
    .big_ext_o (al_big_ext),
    .small_al_o(al_small)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid   <= 1'b0;
      s1_big_exp <= '0;
      s1_big_ext <= '0;
      s1_small   <= '0;
    end else begin
      s1_valid <= go;
      if (go) begin
        s1_big_exp <= al_big_exp;
        s1_big_ext <= al_big_ext;
        s1_small   <= al_small;
      end
    end
  end

  assign sum = {s1_big_ext[W1-1], s1_big_ext} + {s1_small[W1-1], s1_small};

  tcfa_rsb_count #(.W(W2), .CNT_W(CNT_W)) u_rsb (
    .word_i(sum),
    .cnt_o (rsb)
  );

  tcfa_norm_round #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .RND_MODE(RND_MODE), .W2(W2), .CNT_W(CNT_W)
  ) u_norm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .sum_i    (sum),
    .cnt_i    (rsb),
    .big_exp_i(s1_big_exp),
    .exp_o    (nr_exp),
    .sig_o    (nr_sig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_valid_o <= 1'b0;
      sum_exp_o   <= '0;
      sum_sig_o   <= '0;
    end else begin
      sum_valid_o <= s1_valid;
      if (s1_valid) begin
        sum_exp_o <= nr_exp;
        sum_sig_o <= nr_sig;
      end
    end
  end

  a_r1_stage_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i != b_valid_i) |=> !s1_valid);

  a_r1_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> sum_valid_o);

  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> !sum_valid_o);

  a_r6_out_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_valid_o && sum_sig_o != '0) |-> (sum_sig_o[MAN_W-1] != sum_sig_o[MAN_W-2]));

  a_r7_out_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_valid_o && sum_sig_o == '0) |-> (sum_exp_o == EXP_MIN));
endmodule

// File: tb/tc_float_adder_test.sv
module tc_float_adder_test;
  import tcfa_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W = 6;
  localparam int MAN_W = 6;
  localparam int W1    = MAN_W + 1;
  localparam int W2    = MAN_W + 2;
  localparam int EMIN  = -(1 << (EXP_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
  logic [MAN_W-1:0] a_sig = '0, b_sig = '0;
  logic             r_valid, t_valid;
  logic [EXP_W-1:0] r_exp, t_exp;
  logic [MAN_W-1:0] r_sig, t_sig;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tc_float_adder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .RND_MODE(RND_HALF_UP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_valid_i(a_valid), .a_exp_i(a_exp), .a_sig_i(a_sig),
    .b_valid_i(b_valid), .b_exp_i(b_exp), .b_sig_i(b_sig),
    .sum_valid_o(r_valid), .sum_exp_o(r_exp), .sum_sig_o(r_sig)
  );

  tc_float_adder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .RND_MODE(RND_TRUNC)) uut_trunc (
    .clk_i(clk), .rst_ni(rst_n),
    .a_valid_i(a_valid), .a_exp_i(a_exp), .a_sig_i(a_sig),
    .b_valid_i(b_valid), .b_exp_i(b_exp), .b_sig_i(b_sig),
    .sum_valid_o(t_valid), .sum_exp_o(t_exp), .sum_sig_o(t_sig)
  );

  task automatic check(input bit ok, input string req, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic void model(input int ae, input int sa, input int be, input int sb,
                                input bit rnd, output int re, output int rs);
    int ea, eb, big, sml, ebig, d, s2, sum, n, r, res, g;
    ea = (sa == 0) ? EMIN : ae;
    eb = (sb == 0) ? EMIN : be;
    if (ea >= eb) begin big = sa; sml = sb; ebig = ea; d = ea - eb; end
    else          begin big = sb; sml = sa; ebig = eb; d = eb - ea; end
    if (d > W1) d = W1;
    s2  = (sml * 2) >>> d;
    sum = big * 2 + s2;
    if (sum == 0) begin re = EMIN; rs = 0; return; end
    n = sum; r = 0;
    while (n * 2 >= -(1 << (W2 - 1)) && n * 2 < (1 << (W2 - 1))) begin n = n * 2; r++; end
    res = n >>> 2;
    g   = (n >>> 1) & 1;
    re  = ebig + 1 - r;
    if (rnd) begin
      res = res + g;
      if (res >= (1 << (MAN_W - 1))) begin res = res >>> 1; re++; end
      else if (res >= -(1 << (MAN_W - 2)) && res < (1 << (MAN_W - 2))) begin res = res * 2; re--; end
    end
    rs = res;
  endfunction

  task automatic drive(input int ae, input int sa, input int be, input int sb);
    a_exp = EXP_W'(ae); a_sig = MAN_W'(sa);
    b_exp = EXP_W'(be); b_sig = MAN_W'(sb);
    a_valid = 1'b1; b_valid = 1'b1;
  endtask

  task automatic expect_out(input string req, input int ae, input int sa, input int be, input int sb);
    int re, rs, te, ts;
    model(ae, sa, be, sb, 1'b1, re, rs);
    model(ae, sa, be, sb, 1'b0, te, ts);
    check(r_valid && $signed(r_exp) == re && $signed(r_sig) == rs, req,
          $sformatf("round %0d@%0d + %0d@%0d got v%0d %0d@%0d exp v1 %0d@%0d",
                    sa, ae, sb, be, r_valid, $signed(r_sig), $signed(r_exp), rs, re));
    check(t_valid && $signed(t_exp) == te && $signed(t_sig) == ts, req,
          $sformatf("trunc %0d@%0d + %0d@%0d got v%0d %0d@%0d exp v1 %0d@%0d",
                    sa, ae, sb, be, t_valid, $signed(t_sig), $signed(t_exp), ts, te));
  endtask

  // one operation: drive, idle one cycle, sample after second rising edge
  task automatic run_op(input string req, input int ae, input int sa, input int be, input int sb);
    @(negedge clk); drive(ae, sa, be, sb);
    @(negedge clk); a_valid = 1'b0; b_valid = 1'b0;
    @(negedge clk); expect_out(req, ae, sa, be, sb);
  endtask

  task automatic run_fixed(input string req, input int ae, input int sa, input int be, input int sb,
                           input int xr_e, input int xr_s, input int xt_e, input int xt_s);
    @(negedge clk); drive(ae, sa, be, sb);
    @(negedge clk); a_valid = 1'b0; b_valid = 1'b0;
    @(negedge clk);
    check(r_valid && $signed(r_exp) == xr_e && $signed(r_sig) == xr_s, req,
          $sformatf("round got %0d@%0d exp %0d@%0d", $signed(r_sig), $signed(r_exp), xr_s, xr_e));
    check(t_valid && $signed(t_exp) == xt_e && $signed(t_sig) == xt_s, req,
          $sformatf("trunc got %0d@%0d exp %0d@%0d", $signed(t_sig), $signed(t_exp), xt_s, xt_e));
  endtask

  function automatic bit is_norm(input int v);
    return (v == 0) || (v >= (1 << (MAN_W - 2))) || (v < -(1 << (MAN_W - 2)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hang exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(!r_valid && r_exp == '0 && r_sig == '0 && !t_valid, "R1",
          $sformatf("reset got v%0d %0d@%0d exp v0 0@0", r_valid, r_sig, r_exp));
    rst_n = 1'b1;
    @(negedge clk);

    // R1: single strobe starts nothing
    a_exp = '0; a_sig = MAN_W'(20); b_exp = '0; b_sig = MAN_W'(20);
    a_valid = 1'b1; b_valid = 1'b0;
    @(negedge clk); a_valid = 1'b0; b_valid = 1'b1;
    @(negedge clk); b_valid = 1'b0;
    check(!r_valid && !t_valid, "R1", $sformatf("single strobe got v%0d exp v0", r_valid));
    @(negedge clk);
    check(!r_valid && !t_valid, "R1", $sformatf("single strobe got v%0d exp v0", r_valid));

    // named corner cases
    run_fixed("R5",  0, 31,  0, 31,  1, 31,  1, 31);
    run_fixed("R7",  0, 20,  0, -20, EMIN, 0, EMIN, 0);
    run_fixed("R8",  20, 0,  0, 20,  0, 20,  0, 20);
    run_fixed("R9",  0, 17, -1, 17,  0, 26,  0, 25);
    run_fixed("R4",  9, 16,  0, 17,  9, 16,  9, 16);
    run_fixed("R4",  9, 31,  0, -17, 9, 31,  9, 30);
    run_fixed("R3",  0, 17,  0, 30,  1, 24,  1, 23);

    // R10: three back-to-back operations
    @(negedge clk); drive(0, 20, 0, 20);
    @(negedge clk); drive(2, -30, 0, 17);
    @(negedge clk); drive(-3, 0, 4, -25); expect_out("R10", 0, 20, 0, 20);
    @(negedge clk); a_valid = 1'b0; b_valid = 1'b0; expect_out("R10", 2, -30, 0, 17);
    @(negedge clk); expect_out("R10", -3, 0, 4, -25);
    @(negedge clk);
    check(!r_valid && !t_valid, "R10", $sformatf("after stream got v%0d exp v0", r_valid));

    // sweep: all normalised pairs, exponent differences past saturation
    for (int ae = -9; ae <= 9; ae++) begin
      for (int sa = -(1 << (MAN_W - 1)); sa < (1 << (MAN_W - 1)); sa++) begin
        if (!is_norm(sa)) continue;
        for (int sb = -(1 << (MAN_W - 1)); sb < (1 << (MAN_W - 1)); sb++) begin
          if (!is_norm(sb)) continue;
          if ((sa < 0) != (sb < 0) && sa != 0 && sb != 0) run_op("R6", ae, sa, 0, sb);
          else if (ae < 0)                                 run_op("R3", ae, sa, 0, sb);
          else                                             run_op("R2", ae, sa, 0, sb);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule